// File: doc/BRIEF.md
# Six-Step Commutation Gate Driver

This block drives the six gate signals of a three-phase inverter for a brushless DC motor. It uses six-step commutation. A command carries a 3-bit step index, a Q15 duty value and a Q15 period-scaling value. For each command the block computes an active PWM period and a shared compare value. The period is the scaling value times the maximum-period parameter `PER_MAX`. The compare value is derived from the duty and that period. The results are held in a pending shadow. An up-counting, edge-aligned timer runs at the active period. At the next counter wrap, the shadow becomes active all at once.

In every valid step, three gates carry the drive. The upper switch of the sourcing phase is chopped by PWM. The lower switch of the sinking phase is held on. Every other gate is held off, so the third phase floats. A per-step action word of six 2-bit codes selects what each gate does.

Commands use a valid/ready handshake. `cmd_ready` is high whenever no command is pending. A command is taken on a clock edge where `cmd_valid` and `cmd_ready` are both high. `cmd_ready` then stays low until the counter wraps and the command becomes active. While it is low, the source must hold `cmd_valid` and the payload steady.

Top module: `sixstep_gate_drive`

## Requirements
- R1: Step index 0..5 selects action words 0x0C2, 0xC02, 0xC20, 0x02C, 0x20C, 0x2C0. These give current paths A→B, A→C, B→C, B→A, C→A, C→B, with floating phase C, B, A, C, B, A.
- R2: Gate k (0..5) takes action code word[2k+1:2k]: 00 off, 01 inverted PWM, 10 PWM, 11 on. Gates 0/1 are phase A upper/lower, 2/3 are phase B upper/lower, and 4/5 are phase C upper/lower.
- R3: The active period is P = (scale × PER_MAX) >> 15. The counter runs 0..P−1 and then wraps to 0. When P = 0 the counter stays at 0.
- R4: With ACTIVE_HIGH = 1, the compare value is C = ((0x7FFF − duty) × P) >> 15.
- R5: With ACTIVE_HIGH = 0, the compare value is C = (duty × P) >> 15.
- R6: The PWM signal is high while C ≤ counter < P. One compare value serves all three phases.
- R7: An accepted command takes effect only on the edge where the counter wraps. `cmd_ready` is low from acceptance until that edge.
- R8: Step indices 6 and 7 select an all-off action word, so all six gates are low.
- R9: A synchronous active-high reset does the following: gates low, `cmd_ready` high, counter 0, active period and compare both (0x7FFF × PER_MAX) >> 15, action word all off.
- R10: Both gates of one phase are never high together, and at most two gates are high at once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| cmd_valid | input | 1 | Command payload is valid |
| cmd_ready | output | 1 | Block can accept a command |
| cmd_step | input | 3 | Commutation step index |
| cmd_duty | input | 15 | Duty value, Q15 |
| cmd_scale | input | 15 | Period-scaling value, Q15 |
| gate | output | 6 | Gate drives, phase A upper at bit 0 |

## Verification
The bench builds two copies with `PER_MAX` = 40. One has ACTIVE_HIGH = 1 and the other ACTIVE_HIGH = 0. Both receive the same commands, so both compare formulas are checked against the same counter timeline. The small maximum period brings every counter value of a whole PWM cycle within cycle-by-cycle checking. This covers periods of 39, 20, 10, 1 and 0, compare values at 0 and at P−1, and the reset period. It also allows timing the wait of a command sent in mid-cycle.

// File: rtl/sixstep_pkg.sv
package sixstep_pkg;

  typedef enum logic [1:0] {
    GA_OFF   = 2'b00,
    GA_PWM_N = 2'b01,
    GA_PWM   = 2'b10,
    GA_ON    = 2'b11
  } gate_act_e;

  localparam int NUM_GATES = 6;
  localparam int WORD_W    = 2 * NUM_GATES;
  localparam int Q15_W     = 15;
  localparam logic [Q15_W-1:0] Q15_ONE = 15'h7FFF;

  // Builds the action word from the sourcing and sinking phase (0=A,1=B,2=C).
  function automatic logic [WORD_W-1:0] path_word(input int unsigned src,
                                                  input int unsigned snk);
    logic [WORD_W-1:0] w;
    w = '0;
    w[4*src +: 2]     = GA_PWM;
    w[4*snk + 2 +: 2] = GA_ON;
    return w;
  endfunction

  // Step index to action word; indices beyond the six steps give all-off.
  function automatic logic [WORD_W-1:0] step_word(input logic [2:0] step);
    case (step)
      3'd0:    return path_word(0, 1);
      3'd1:    return path_word(0, 2);
      3'd2:    return path_word(1, 2);
      3'd3:    return path_word(1, 0);
      3'd4:    return path_word(2, 0);
      3'd5:    return path_word(2, 1);
      default: return '0;
    endcase
  endfunction

endpackage

// File: rtl/sixstep_scaler.sv
module sixstep_scaler
  import sixstep_pkg::*;
#(
  parameter int PER_MAX     = 1000,
  parameter int PW          = 10,
  parameter bit ACTIVE_HIGH = 1'b1
) (
  input  logic [Q15_W-1:0] scale,
  input  logic [Q15_W-1:0] duty,
  output logic [PW-1:0]    period,
  output logic [PW-1:0]    cmp
);
  localparam int            PROD_W = Q15_W + PW;
  localparam logic [PW-1:0] PMAX   = PW'(PER_MAX);

  logic [PROD_W-1:0] per_prod;
  logic [PROD_W-1:0] cmp_prod;
  logic [Q15_W-1:0]  duty_eff;

  generate
    if (ACTIVE_HIGH) begin : g_hi
      assign duty_eff = Q15_ONE - duty;
    end else begin : g_lo
      assign duty_eff = duty;
    end
  endgenerate

  always_comb begin
    per_prod = PROD_W'(scale) * PROD_W'(PMAX);
    period   = per_prod[Q15_W +: PW];
    cmp_prod = PROD_W'(duty_eff) * PROD_W'(period);
    cmp      = cmp_prod[Q15_W +: PW];
  end

endmodule

// File: rtl/sixstep_pwm_timer.sv
module sixstep_pwm_timer
  import sixstep_pkg::*;
#(
  parameter int PW         = 10,
  parameter int RST_PERIOD = 999
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load_en,
  input  logic [PW-1:0]     ld_period,
  input  logic [PW-1:0]     ld_cmp,
  input  logic [WORD_W-1:0] ld_word,
  output logic              pend_vld,
  output logic [PW-1:0]     cnt,
  output logic              wrap,
  output logic [PW-1:0]     act_period,
  output logic [PW-1:0]     act_cmp,
  output logic [WORD_W-1:0] act_word,
  output logic              pwm
);
  localparam logic [PW-1:0] RST_P = PW'(RST_PERIOD);

  logic [PW-1:0]     pend_period;
  logic [PW-1:0]     pend_cmp;
  logic [WORD_W-1:0] pend_word;
  logic [PW-1:0]     last;

  always_comb begin
    last = (act_period == '0) ? '0 : act_period - 1'b1;
    wrap = (cnt >= last);
    pwm  = (cnt >= act_cmp) && (cnt < act_period);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt         <= '0;
      pend_vld    <= 1'b0;
      pend_period <= '0;
      pend_cmp    <= '0;
      pend_word   <= '0;
      act_period  <= RST_P;
      act_cmp     <= RST_P;
      act_word    <= '0;
    end else begin
      cnt <= wrap ? '0 : cnt + 1'b1;
      if (pend_vld) begin
        if (wrap) begin
          act_period <= pend_period;
          act_cmp    <= pend_cmp;
          act_word   <= pend_word;
          pend_vld   <= 1'b0;
        end
      end else if (load_en) begin
        pend_period <= ld_period;
        pend_cmp    <= ld_cmp;
        pend_word   <= ld_word;
        pend_vld    <= 1'b1;
      end
    end
  end

endmodule

// File: rtl/sixstep_gate_map.sv
module sixstep_gate_map
  import sixstep_pkg::*;
(
  input  logic [WORD_W-1:0]    word,
  input  logic                 pwm,
  output logic [NUM_GATES-1:0] gate
);
  generate
    for (genvar g = 0; g < NUM_GATES; g++) begin : g_pin
      gate_act_e act;
      assign act = gate_act_e'(word[2*g +: 2]);
      always_comb begin
        case (act)
          GA_PWM_N: gate[g] = ~pwm;
          GA_PWM:   gate[g] = pwm;
          GA_ON:    gate[g] = 1'b1;
          default:  gate[g] = 1'b0;
        endcase
      end
    end
  endgenerate
endmodule

// File: rtl/sixstep_gate_drive.sv
module sixstep_gate_drive
  import sixstep_pkg::*;
#(
  parameter int PER_MAX     = 1000,
  parameter bit ACTIVE_HIGH = 1'b1
) (
  input  logic        clk,
  input  logic        rst,
  input  logic        cmd_valid,
  output logic        cmd_ready,
  input  logic [2:0]  cmd_step,
  input  logic [14:0] cmd_duty,
  input  logic [14:0] cmd_scale,
  output logic [5:0]  gate
);
  localparam int PW         = $clog2(PER_MAX + 1);
  localparam int RST_PERIOD = (32767 * PER_MAX) / 32768;

  logic [PW-1:0]     ld_period;
  logic [PW-1:0]     ld_cmp;
  logic [WORD_W-1:0] ld_word;
  logic              load_en;
  logic              pend_vld;
  logic [PW-1:0]     cnt;
  logic              wrap;
  logic [PW-1:0]     act_period;
  logic [PW-1:0]     act_cmp;
  logic [WORD_W-1:0] act_word;
  logic              pwm;

  assign cmd_ready = ~pend_vld;
  assign load_en   = cmd_valid & cmd_ready;
  assign ld_word   = step_word(cmd_step);

  sixstep_scaler #(
    .PER_MAX    (PER_MAX),
    .PW         (PW),
    .ACTIVE_HIGH(ACTIVE_HIGH)
  ) u_scaler (
    .scale (cmd_scale),
    .duty  (cmd_duty),
    .period(ld_period),
    .cmp   (ld_cmp)
  );

  sixstep_pwm_timer #(
    .PW        (PW),
    .RST_PERIOD(RST_PERIOD)
  ) u_timer (
    .clk       (clk),
    .rst       (rst),
    .load_en   (load_en),
    .ld_period (ld_period),
    .ld_cmp    (ld_cmp),
    .ld_word   (ld_word),
    .pend_vld  (pend_vld),
    .cnt       (cnt),
    .wrap      (wrap),
    .act_period(act_period),
    .act_cmp   (act_cmp),
    .act_word  (act_word),
    .pwm       (pwm)
  );

  sixstep_gate_map u_map (
    .word(act_word),
    .pwm (pwm),
    .gate(gate)
  );

endmodule

// File: rtl/sixstep_gate_drive_chk.sv
module sixstep_gate_drive_chk #(
  parameter int PW = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          cmd_valid,
  input logic          cmd_ready,
  input logic [5:0]    gate,
  input logic [PW-1:0] cnt,
  input logic          wrap,
  input logic [PW-1:0] act_period,
  input logic [PW-1:0] act_cmp,
  input logic [11:0]   act_word
);

  assert_reset_state_R9: assert property (@(posedge clk)
    rst |=> (gate == 6'b0) && cmd_ready && (cnt == '0));

  assert_cnt_in_range_R3: assert property (@(posedge clk) disable iff (rst)
    (act_period == '0) ? (cnt == '0) : (cnt < act_period));

  assert_wrap_to_zero_R3: assert property (@(posedge clk) disable iff (rst)
    wrap |=> (cnt == '0));

  assert_shadow_hold_R7: assert property (@(posedge clk) disable iff (rst)
    !wrap |=> $stable(act_word) && $stable(act_cmp) && $stable(act_period));

  assert_backpressure_R7: assert property (@(posedge clk) disable iff (rst)
    (cmd_valid && cmd_ready) |=> !cmd_ready);

  assert_all_off_word_R8: assert property (@(posedge clk) disable iff (rst)
    (act_word == 12'h000) |-> (gate == 6'b0));

  assert_no_shoot_through_R10: assert property (@(posedge clk) disable iff (rst)
    !(gate[0] && gate[1]) && !(gate[2] && gate[3]) && !(gate[4] && gate[5]));

  assert_gate_count_R10: assert property (@(posedge clk) disable iff (rst)
    $countones(gate) <= 2);

endmodule

bind sixstep_gate_drive sixstep_gate_drive_chk #(.PW(PW)) u_chk (
  .clk       (clk),
  .rst       (rst),
  .cmd_valid (cmd_valid),
  .cmd_ready (cmd_ready),
  .gate      (gate),
  .cnt       (cnt),
  .wrap      (wrap),
  .act_period(act_period),
  .act_cmp   (act_cmp),
  .act_word  (act_word)
);

// File: tb/test_sixstep_gate_drive.sv
module test_sixstep_gate_drive;
  localparam int PMAX = 40;
  localparam int NV   = 10;
  // {step[2:0], duty[14:0], scale[14:0]}
  localparam logic [32:0] VEC [NV] = '{
    {3'd1, 15'h7FFF, 15'h7FFF},
    {3'd2, 15'h0000, 15'h4000},
    {3'd3, 15'h2000, 15'h6000},
    {3'd4, 15'h1234, 15'h7FFF},
    {3'd5, 15'h6000, 15'h2000},
    {3'd6, 15'h4000, 15'h7FFF},
    {3'd7, 15'h4000, 15'h7FFF},
    {3'd0, 15'h4000, 15'h0000},
    {3'd2, 15'h4000, 15'h0400},
    {3'd0, 15'h0100, 15'h7FFF}
  };

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_valid = 1'b0;
  logic [2:0]  cmd_step = '0;
  logic [14:0] cmd_duty = '0;
  logic [14:0] cmd_scale = '0;
  logic        ready_hi, ready_lo;
  logic [5:0]  gate_hi, gate_lo;
  int          total = 0;
  int          fails = 0;

  always #2 clk = ~clk;

  sixstep_gate_drive #(.PER_MAX(PMAX), .ACTIVE_HIGH(1'b1)) i_sixstep_gate_drive (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(ready_hi),
    .cmd_step(cmd_step), .cmd_duty(cmd_duty), .cmd_scale(cmd_scale), .gate(gate_hi));

  sixstep_gate_drive #(.PER_MAX(PMAX), .ACTIVE_HIGH(1'b0)) i_sixstep_gate_drive_lo (
    .clk(clk), .rst(rst), .cmd_valid(cmd_valid), .cmd_ready(ready_lo),
    .cmd_step(cmd_step), .cmd_duty(cmd_duty), .cmd_scale(cmd_scale), .gate(gate_lo));

  function automatic logic [11:0] word_of(input logic [2:0] s);
    case (s)
      3'd0: return 12'h0C2;
      3'd1: return 12'hC02;
      3'd2: return 12'hC20;
      3'd3: return 12'h02C;
      3'd4: return 12'h20C;
      3'd5: return 12'h2C0;
      default: return 12'h000;
    endcase
  endfunction

  function automatic logic [5:0] exp_gates(input logic [11:0] w, input logic p);
    logic [5:0] g;
    for (int i = 0; i < 6; i++) begin
      case (w[2*i +: 2])
        2'b00: g[i] = 1'b0;
        2'b01: g[i] = ~p;
        2'b10: g[i] = p;
        default: g[i] = 1'b1;
      endcase
    end
    return g;
  endfunction

  function automatic int per_of(input logic [14:0] s);
    return (int'(s) * PMAX) >> 15;
  endfunction

  function automatic int cmp_hi(input logic [14:0] d, input int p);
    return ((32767 - int'(d)) * p) >> 15;
  endfunction

  function automatic int cmp_lo(input logic [14:0] d, input int p);
    return (int'(d) * p) >> 15;
  endfunction

  task automatic check(input bit ok, input string req, input int act, input int expv);
    total++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  // Called at a falling edge where the counter is 0 under the given settings.
  task automatic run_window(input logic [2:0] s, input logic [14:0] d, input logic [14:0] sc);
    int p, ch, cl, n, bad_h, bad_l, bad_s, first_h, first_l;
    logic [11:0] w;
    w = word_of(s);
    p = per_of(sc);
    ch = cmp_hi(d, p);
    cl = cmp_lo(d, p);
    n = (p == 0) ? 1 : p;
    bad_h = 0; bad_l = 0; bad_s = 0; first_h = 0; first_l = 0;
    for (int k = 0; k < n; k++) begin
      logic [5:0] eh, el;
      eh = exp_gates(w, (k >= ch) && (k < p));
      el = exp_gates(w, (k >= cl) && (k < p));
      if (gate_hi !== eh) begin
        if (bad_h == 0) first_h = int'(gate_hi) * 100 + int'(eh);
        bad_h++;
      end
      if (gate_lo !== el) begin
        if (bad_l == 0) first_l = int'(gate_lo) * 100 + int'(el);
        bad_l++;
      end
      if ((gate_hi[0] & gate_hi[1]) | (gate_hi[2] & gate_hi[3]) |
          (gate_hi[4] & gate_hi[5]) | ($countones(gate_hi) > 2)) bad_s++;
      @(negedge clk);
    end
    if (s > 3'd5)
      check(bad_h == 0, "R8 all gates low for invalid step (gate*100+exp)", first_h, 0);
    else
      check(bad_h == 0, "R1 R2 R3 R4 R6 gate pattern (gate*100+exp)", first_h, 0);
    check(bad_l == 0, "R5 active-low compare pattern (gate*100+exp)", first_l, 0);
    check(bad_s == 0, "R10 shoot-through cycles", bad_s, 0);
  endtask

  task automatic send(input logic [2:0] s, input logic [14:0] d, input logic [14:0] sc);
    cmd_step = s; cmd_duty = d; cmd_scale = sc; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    while (!ready_hi) @(negedge clk);
  endtask

  initial begin
    #(200000 * 4);
    total++; fails++;
    $display("FAIL watchdog R7: run did not end, actual timeout expected completion");
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

  initial begin
    int n, k;
    repeat (3) @(negedge clk);
    check(gate_hi == 6'b0 && gate_lo == 6'b0, "R9 gates low in reset", int'(gate_hi), 0);
    check(ready_hi == 1'b1, "R9 ready high in reset", int'(ready_hi), 1);

    // Reset period: a command sent on the first cycle waits one reset period.
    rst = 1'b0;
    cmd_step = 3'd0; cmd_duty = 15'h4000; cmd_scale = 15'h7FFF; cmd_valid = 1'b1;
    @(negedge clk);
    cmd_valid = 1'b0;
    n = 1;
    while (!ready_hi) begin @(negedge clk); n++; end
    check(n == (32767 * PMAX) / 32768, "R9 reset period length", n, (32767 * PMAX) / 32768);
    run_window(3'd0, 15'h4000, 15'h7FFF);

    // Table walk
    for (int v = 0; v < NV; v++) begin
      send(VEC[v][32:30], VEC[v][29:15], VEC[v][14:0]);
      run_window(VEC[v][32:30], VEC[v][29:15], VEC[v][14:0]);
    end

    // R7: a command sent in mid-cycle leaves the running cycle untouched.
    send(3'd0, 15'h4000, 15'h7FFF);
    k = 0;
    n = 0;
    for (int i = 0; i < 5; i++) begin @(negedge clk); k++; end
    cmd_step = 3'd3; cmd_duty = 15'h7FFF; cmd_scale = 15'h4000; cmd_valid = 1'b1;
    @(negedge clk);
    k++;
    cmd_valid = 1'b0;
    check(ready_hi == 1'b0, "R7 ready low while command pending", int'(ready_hi), 0);
    while (!ready_hi) begin
      if (gate_hi !== exp_gates(12'h0C2, (k >= cmp_hi(15'h4000, 39)) && (k < 39))) n++;
      @(negedge clk);
      k++;
    end
    check(n == 0, "R7 old pattern held until wrap (mismatch cycles)", n, 0);
    check(k == 39, "R7 new command applied at wrap (cycle index)", k, 39);
    run_window(3'd3, 15'h7FFF, 15'h4000);

    // R9: reset in mid-run clears the drive.
    repeat (3) @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    check(gate_hi == 6'b0 && gate_lo == 6'b0, "R9 gates low after mid-run reset", int'(gate_hi), 0);
    check(ready_hi == 1'b1, "R9 ready high after mid-run reset", int'(ready_hi), 1);
    rst = 1'b0;
    @(negedge clk);

    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end
endmodule